// File: doc/BRIEF.md
# Staircase Fundamental-Frequency Level Modulator

This block converts a phase-angle word into a stepped, near-sinusoidal level command for one leg of an 11-level modular multilevel converter. Each arm of the leg holds ten sub-modules. The block folds the angle into the first quarter of the cycle using quarter-wave symmetry. It then counts how many of five stored switching thresholds the folded angle has reached, which gives a signed level from -5 to +5.

The level is turned into the number of sub-modules to insert in the upper arm and in the lower arm. A strobe flags every cycle in which the upper-arm count changes. As the phase sweeps one full turn, each step of the staircase changes only once per period in each direction, so the switching rate equals the fundamental rate. The five thresholds can be rewritten through a small load port.

Top module: `stair_level_mod`

## Requirements
- R1: While reset is low and in the first cycle after it, the outputs are level 0, upper count 5, lower count 5 and strobe 0. Reset also restores the default thresholds 1859, 3776, 5818, 8108 and 10939, which are 10.21, 20.74, 31.96, 44.54 and 60.09 degrees on a 65536-per-turn scale.
- R2: The upper and lower counts always add up to 10.
- R3: For a phase p in 0..16383, sampled at a clock edge, the level after that edge is the number of thresholds less than or equal to p.
- R4: For a phase p in 16384..32767, the level is the number of thresholds less than or equal to 32768-p. This makes the 90 to 180 degree span the mirror image of the first quarter.
- R5: For a phase p in 32768..65535, the level is the negative of the level that phase p-32768 would give.
- R6: A level k gives an upper count of 5-k and a lower count of 5+k. The level is a 5-bit two's-complement value in the range -5..+5.
- R7: The strobe is high for exactly the cycles in which the upper count differs from its value in the previous cycle.
- R8: When the write enable is high and the index is 0..4, the threshold at that index takes the written value, and the new value is used from the next clock edge. An index of 5..7 changes no threshold, so the level output is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 16 | Phase angle, a full turn spread over 0..65535 |
| tbl_we | input | 1 | Threshold write enable |
| tbl_idx | input | 3 | Index of the threshold to write |
| tbl_val | input | 16 | New threshold value, on the phase scale |
| level | output | 5 | Signed staircase level, -5..+5 |
| upper_cnt | output | 4 | Sub-modules to insert in the upper arm |
| lower_cnt | output | 4 | Sub-modules to insert in the lower arm |
| level_change | output | 1 | One-cycle strobe when the upper count changes |

## Verification
All four outputs come from a single register stage. A phase applied before a clock edge is therefore due on level, upper_cnt, lower_cnt and level_change right after that edge. A threshold write takes effect at the edge on which it is sampled, so it first shapes the result for the phase presented one cycle later.

The bench drives its inputs on the falling edge. On each following falling edge it compares every output against a model that computes the level from the previous stimulus and the threshold table as it stood before that stimulus. This keeps each check exactly one edge behind its cause.

// File: rtl/stair_level_mod.sv
module stair_level_mod #(
  parameter int PW = 16,
  parameter int STEPS = 5,
  parameter logic [STEPS*PW-1:0] ANG_DEF =
    {16'd10939, 16'd8108, 16'd5818, 16'd3776, 16'd1859}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PW-1:0]               phase,
  input  logic                        tbl_we,
  input  logic [$clog2(STEPS+3)-1:0]  tbl_idx,
  input  logic [PW-1:0]               tbl_val,
  output logic signed [$clog2(2*STEPS+1):0] level,
  output logic [$clog2(2*STEPS+1)-1:0] upper_cnt,
  output logic [$clog2(2*STEPS+1)-1:0] lower_cnt,
  output logic                        level_change
);
  localparam int ARM_N = 2 * STEPS;
  localparam int CW = $clog2(ARM_N + 1);
  localparam logic [PW-1:0] QTR = PW'(1) << (PW - 2);

  logic [PW-1:0] thr [STEPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STEPS; i++) thr[i] <= ANG_DEF[i*PW +: PW];
    end else if (tbl_we && int'(tbl_idx) < STEPS) begin
      thr[tbl_idx] <= tbl_val;
    end
  end

  wire [PW-1:0] off  = {2'b00, phase[PW-3:0]};
  wire [PW-1:0] fold = phase[PW-2] ? (QTR - off) : off;
  wire          neg  = phase[PW-1];

  logic [CW-1:0] cnt;
  always_comb begin
    cnt = '0;
    for (int i = 0; i < STEPS; i++)
      if (thr[i] <= fold) cnt = cnt + 1'b1;
  end

  wire signed [CW:0] lvl_n = neg ? -$signed({1'b0, cnt}) : $signed({1'b0, cnt});
  wire [CW-1:0] up_n = CW'(STEPS - int'(lvl_n));
  wire [CW-1:0] lo_n = CW'(STEPS + int'(lvl_n));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level        <= '0;
      upper_cnt    <= CW'(STEPS);
      lower_cnt    <= CW'(STEPS);
      level_change <= 1'b0;
    end else begin
      level        <= lvl_n;
      upper_cnt    <= up_n;
      lower_cnt    <= lo_n;
      level_change <= (up_n != upper_cnt);
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (level == 0 && upper_cnt == CW'(STEPS) && lower_cnt == CW'(STEPS) && !level_change));

  assert_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(upper_cnt) + int'(lower_cnt) == ARM_N);

  assert_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) >= -STEPS && int'(level) <= STEPS && int'(upper_cnt) == STEPS - int'(level));

  assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level_change |-> (upper_cnt != $past(upper_cnt)));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !level_change |-> $stable(upper_cnt));
endmodule

// File: tb/tb_stair_level_mod.sv
`timescale 1ns/1ps
module tb_stair_level_mod;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] phase = '0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_idx = '0;
  logic [15:0] tbl_val = '0;
  logic signed [4:0] level;
  logic [3:0] upper_cnt, lower_cnt;
  logic level_change;

  stair_level_mod dut (
    .clk(clk), .rst_n(rst_n), .phase(phase), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_val(tbl_val), .level(level),
    .upper_cnt(upper_cnt), .lower_cnt(lower_cnt), .level_change(level_change)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int thr_m [5];
  int exp_lvl, exp_up, exp_lo, exp_chg;
  string exp_tag;
  bit dirty;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    thr_m = '{1859, 3776, 5818, 8108, 10939};
    exp_lvl = 0; exp_up = 5; exp_lo = 5; exp_chg = 0;
    exp_tag = "R1"; dirty = 0;
  endtask

  function automatic int ref_level(int ph);
    int q = ph >> 14;
    int off = ph & 16383;
    int f = (q % 2 == 1) ? 16384 - off : off;
    int c = 0;
    for (int i = 0; i < 5; i++) if (thr_m[i] <= f) c++;
    return (q >= 2) ? -c : c;
  endfunction

  task automatic compare();
    check(exp_tag, "level", int'(level), exp_lvl);
    check("R6", "upper_cnt", int'(upper_cnt), exp_up);
    check("R6", "lower_cnt", int'(lower_cnt), exp_lo);
    check("R2", "sum", int'(upper_cnt) + int'(lower_cnt), 10);
    check("R7", "level_change", int'(level_change), exp_chg);
  endtask

  task automatic step(int ph, bit we = 0, int idx = 0, int val = 0);
    int nl;
    @(negedge clk);
    compare();
    phase = 16'(ph); tbl_we = we; tbl_idx = 3'(idx); tbl_val = 16'(val);
    nl = ref_level(ph);
    exp_chg = ((5 - nl) != exp_up);
    exp_lvl = nl; exp_up = 5 - nl; exp_lo = 5 + nl;
    exp_tag = dirty ? "R8" : ((ph >> 14) == 0 ? "R3" : ((ph >> 14) == 1 ? "R4" : "R5"));
    if (we && idx < 5) begin thr_m[idx] = val; dirty = 1; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tbl_we = 0;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R3 R4 R5: two full sweeps
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < 65536; p += 97) step(p);
    // Boundaries around thresholds and quadrant edges
    foreach (thr_m[i]) begin
      step(thr_m[i] - 1); step(thr_m[i]);
      step(32768 - thr_m[i]); step(32768 - thr_m[i] + 1);
      step(32768 + thr_m[i] - 1); step(32768 + thr_m[i]);
      step(65536 - thr_m[i]); step(65536 - thr_m[i] + 1);
    end
    step(0); step(16383); step(16384); step(16385); step(32767);
    step(32768); step(49151); step(49152); step(65535); step(0);
    // R8: ignored indices, then a real write
    step(12000, 1, 6, 100);
    step(12000, 1, 5, 0);
    step(12000, 1, 7, 20);
    step(12000);
    step(2000, 1, 2, 6000);
    step(5900); step(6000); step(26768); step(58768);
    step(3000, 1, 4, 16384);
    step(16384); step(16383); step(49152);
    for (int p = 0; p < 65536; p += 211) step(p);
    // R1: reset mid-run restores defaults
    do_reset();
    step(5818); step(5817); step(60000);
    for (int k = 0; k < 2000; k++) step(int'($urandom_range(0, 65535)));
    step(0); step(0);
    @(negedge clk);
    compare();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule